// File: doc/BRIEF.md
# Page Translation Cache

This block keeps recently used page translations next to the address path, so that most memory accesses avoid the two table reads that a full walk costs. A 20-bit virtual page number is presented on the lookup port. In the same cycle the block reports whether a usable translation is held, the 20-bit physical frame number, and the read/write and user/supervisor permission bits stored with it. Pages are 4 KB in size, so the low 12 address bits pass around the block untouched.

When a lookup misses, an external walker fetches the translation and hands it back on the refill port. The block chooses the slot itself. Storage is organised as eight sets of four ways, 32 translations in all. A reload of the page directory base register drives the flush input, which discards every held translation at once.

A write lookup that hits an entry whose stored dirty copy is clear is reported as a miss. This sends the access to the walker, which marks the page dirty in memory and then refills the entry with the dirty copy set.

Top module: `page_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns lk_hit=0.
- R2: The set index is lk_vpn[2:0], which is linear address bits 14:12. The tag is lk_vpn[19:3]. Each of the 8 sets has 4 ways, so 32 translations with distinct page numbers can all be held at once.
- R3: A lookup is combinational. When a valid entry in the indexed set has a matching tag, lk_hit, lk_pfn, lk_rw and lk_us show that entry in the same cycle.
- R4: A refill (fill_en=1) is written at the clock edge. The new translation is visible to lookups from the next cycle on.
- R5: A refill whose tag is already held in its set overwrites that way. No other entry in the set is lost.
- R6: If the set has no matching tag and has an invalid way, the refill goes to the lowest-numbered invalid way.
- R7: If the set is full, the refill evicts the way chosen by a 3-bit pseudo-LRU tree. Bit 0 selects the pair: 0 means ways 0/1, 1 means ways 2/3. Bit 1 selects within ways 0/1 (0 means way 0). Bit 2 selects within ways 2/3 (0 means way 2). Every refill updates the tree to point away from the way it wrote. A lookup hit with lk_req=1 also updates the tree to point away from the way it hit. A lookup with lk_req=0 leaves the tree unchanged. The tree is cleared to 0 by reset and by a flush.
- R8: A lookup with lk_write=1 that matches an entry whose dirty copy (fill_dirty at refill) is 0 returns lk_hit=0. A read lookup of the same entry hits.
- R9: base_load=1 invalidates every entry at that clock edge, so all lookups miss from the next cycle. A refill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a write access |
| lk_req | input | 1 | Lookup is a real access; a hit updates replacement order |
| lk_hit | output | 1 | Usable translation found |
| lk_pfn | output | 20 | Physical frame number of the hit |
| lk_rw | output | 1 | Stored read/write permission |
| lk_us | output | 1 | Stored user/supervisor permission |
| fill_en | input | 1 | Refill strobe from the walker |
| fill_vpn | input | 20 | Page number being refilled |
| fill_pfn | input | 20 | Frame number being refilled |
| fill_rw | input | 1 | Read/write permission to store |
| fill_us | input | 1 | User/supervisor permission to store |
| fill_dirty | input | 1 | Dirty copy to store |
| base_load | input | 1 | Directory base reload; flushes all entries |

## Verification
The bench first fills all 32 slots with page numbers that differ in both set and tag, then reads every slot back. This separates a correct split of set index and tag from aliasing, and shows that free ways are taken before any eviction. In one set it then overfills in a known order, mixing lookups that update the replacement order with lookups that do not. It predicts each victim from the tree encoding, which exposes wrong victim choice, wrong tree update and a non-updating lookup that leaks into the order. Rewriting a held tag, write accesses against clean and dirty copies, and a flush that lands together with a refill cover overwrite, the dirty-miss rule and flush priority.

// File: rtl/page_xlate_cache.sv
module page_xlate_cache #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SET_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  input  logic             lk_req,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_rw,
  output logic             lk_us,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_rw,
  input  logic             fill_us,
  input  logic             fill_dirty,
  input  logic             base_load
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 4;
  localparam int TAG_W = VPN_W - SET_W;

  logic [WAYS-1:0]  vld   [SETS];
  logic [TAG_W-1:0] tag   [SETS][WAYS];
  logic [PFN_W-1:0] pfn   [SETS][WAYS];
  logic [WAYS-1:0]  rw    [SETS];
  logic [WAYS-1:0]  us    [SETS];
  logic [WAYS-1:0]  dirty [SETS];
  logic [2:0]       plru  [SETS];

  function automatic logic [2:0] touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (!w[1]) begin n[0] = 1'b1; n[1] = ~w[0]; end
    else       begin n[0] = 1'b0; n[2] = ~w[0]; end
    return n;
  endfunction

  // lookup path
  wire [SET_W-1:0] lk_set = lk_vpn[SET_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_vpn[VPN_W-1:SET_W];
  logic [WAYS-1:0] hit_way;
  logic [1:0]      hit_idx;
  logic            sel_dirty;

  always_comb begin
    lk_pfn    = '0;
    lk_rw     = 1'b0;
    lk_us     = 1'b0;
    sel_dirty = 1'b0;
    hit_idx   = 2'd0;
    for (int w = 0; w < WAYS; w++) begin
      hit_way[w] = vld[lk_set][w] && (tag[lk_set][w] == lk_tag);
      if (hit_way[w]) begin
        lk_pfn    = pfn[lk_set][w];
        lk_rw     = rw[lk_set][w];
        lk_us     = us[lk_set][w];
        sel_dirty = dirty[lk_set][w];
        hit_idx   = 2'(w);
      end
    end
  end

  assign lk_hit = (|hit_way) && !(lk_write && !sel_dirty);

  // refill slot choice: matching tag, then lowest free way, then tree victim
  wire [SET_W-1:0] f_set = fill_vpn[SET_W-1:0];
  wire [TAG_W-1:0] f_tag = fill_vpn[VPN_W-1:SET_W];
  logic [1:0] f_way;
  logic       f_found;

  always_comb begin
    f_found = 1'b0;
    f_way   = plru[f_set][0] ? {1'b1, plru[f_set][2]} : {1'b0, plru[f_set][1]};
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[f_set][w]) begin f_way = 2'(w); f_found = 1'b1; end
    for (int w = 0; w < WAYS; w++)
      if (vld[f_set][w] && tag[f_set][w] == f_tag) f_way = 2'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || base_load) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        plru[s] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld[f_set][f_way]   <= 1'b1;
        tag[f_set][f_way]   <= f_tag;
        pfn[f_set][f_way]   <= fill_pfn;
        rw[f_set][f_way]    <= fill_rw;
        us[f_set][f_way]    <= fill_us;
        dirty[f_set][f_way] <= fill_dirty;
        plru[f_set]         <= touch(plru[f_set], f_way);
      end
      if (lk_req && lk_hit && !(fill_en && f_set == lk_set))
        plru[lk_set] <= touch(plru[lk_set], hit_idx);
    end
  end
endmodule

module page_xlate_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_write,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic             fill_en,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PFN_W-1:0] fill_pfn,
  input logic             fill_dirty,
  input logic             base_load,
  input logic [3:0]       hit_way
);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |=> !lk_hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en && !base_load && rst_n) && !lk_write && lk_vpn == $past(fill_vpn))
      |-> (lk_hit && lk_pfn == $past(fill_pfn)));

  p_clean_write_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en && !fill_dirty && !base_load && rst_n) && lk_write && lk_vpn == $past(fill_vpn))
      |-> !lk_hit);

  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_way));
endmodule

bind page_xlate_cache page_xlate_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_hit(lk_hit),
  .lk_pfn(lk_pfn), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
  .fill_dirty(fill_dirty), .base_load(base_load), .hit_way(hit_way));

// File: tb/page_xlate_cache_tb_top.sv
`timescale 1ns/1ps
module page_xlate_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        lk_write = 1'b0, lk_req = 1'b0;
  logic        lk_hit, lk_rw, lk_us;
  logic [19:0] lk_pfn;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        fill_rw = 1'b0, fill_us = 1'b0, fill_dirty = 1'b0;
  logic        base_load = 1'b0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  page_xlate_cache dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_write(lk_write), .lk_req(lk_req),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rw(lk_rw), .lk_us(lk_us),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_rw(fill_rw),
    .fill_us(fill_us), .fill_dirty(fill_dirty), .base_load(base_load));

  function automatic logic [19:0] vpn_of(int t, int s);
    return {17'(t), 3'(s)};
  endfunction

  function automatic logic [19:0] pfn_of(logic [19:0] v);
    return 20'((v * 7 + 20'h1234) ^ 20'h5A5A5);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input bit d, input bit flush = 1'b0);
    @(negedge clk);
    lk_req = 1'b0;
    fill_en = 1'b1; fill_vpn = v; fill_pfn = p;
    fill_rw = v[3]; fill_us = v[0]; fill_dirty = d; base_load = flush;
    @(negedge clk);
    fill_en = 1'b0; base_load = 1'b0;
  endtask

  task automatic look(input logic [19:0] v, input bit wr, input bit req,
                      input bit exp_hit, input logic [19:0] exp_pfn, input string req_tag);
    @(negedge clk);
    lk_vpn = v; lk_write = wr; lk_req = req;
    #1;
    chk(lk_hit == exp_hit, req_tag, 32'(lk_hit), 32'(exp_hit));
    if (exp_hit) chk(lk_pfn == exp_pfn, req_tag, 32'(lk_pfn), 32'(exp_pfn));
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    for (int s = 0; s < 8; s++) look(vpn_of(5, s), 1'b0, 1'b0, 1'b0, '0, "R1");

    // R2 R6: fill every slot, all held at once
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 4; t++) fill(vpn_of(t * 37 + 5, s), pfn_of(vpn_of(t * 37 + 5, s)), 1'b1);
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 4; t++) begin
        look(vpn_of(t * 37 + 5, s), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(t * 37 + 5, s)), "R2");
        // R3: permissions come back with the frame
        chk(lk_rw == vpn_of(t * 37 + 5, s)[3] && lk_us == vpn_of(t * 37 + 5, s)[0],
            "R3", {30'd0, lk_rw, lk_us}, {30'd0, vpn_of(t * 37 + 5, s)[3], vpn_of(t * 37 + 5, s)[0]});
      end

    // R9: flush empties everything
    @(negedge clk); base_load = 1'b1; @(negedge clk); base_load = 1'b0;
    for (int s = 0; s < 8; s++) look(vpn_of(5, s), 1'b0, 1'b0, 1'b0, '0, "R9");

    // R6/R7 in set 2: T0..T3 to ways 0..3; tree ends at 000 -> victim way0
    for (int t = 0; t < 4; t++) fill(vpn_of(100 + t, 2), pfn_of(vpn_of(100 + t, 2)), 1'b1);
    look(vpn_of(100, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(100, 2)), "R7 nonreq");
    fill(vpn_of(104, 2), pfn_of(vpn_of(104, 2)), 1'b1);
    look(vpn_of(100, 2), 1'b0, 1'b0, 1'b0, '0, "R7 evict way0");
    look(vpn_of(104, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(104, 2)), "R7");
    // tree now 011; hit way1 with req -> 001 -> victim way2 (T2)
    look(vpn_of(101, 2), 1'b0, 1'b1, 1'b1, pfn_of(vpn_of(101, 2)), "R7 req hit");
    fill(vpn_of(105, 2), pfn_of(vpn_of(105, 2)), 1'b1);
    look(vpn_of(102, 2), 1'b0, 1'b0, 1'b0, '0, "R7 evict way2");
    look(vpn_of(101, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(101, 2)), "R7");
    look(vpn_of(103, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(103, 2)), "R7");
    look(vpn_of(105, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(105, 2)), "R7");

    // R5: rewrite a held tag with a new frame
    fill(vpn_of(103, 2), 20'hBEEF1, 1'b1);
    look(vpn_of(103, 2), 1'b0, 1'b0, 1'b1, 20'hBEEF1, "R5");
    look(vpn_of(101, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(101, 2)), "R5");
    look(vpn_of(104, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(104, 2)), "R5");
    look(vpn_of(105, 2), 1'b0, 1'b0, 1'b1, pfn_of(vpn_of(105, 2)), "R5");

    // R8: clean copy misses on write, hits on read; dirty copy hits on write
    fill(vpn_of(200, 5), 20'h0C0DE, 1'b0);
    look(vpn_of(200, 5), 1'b1, 1'b0, 1'b0, '0, "R8 clean write");
    look(vpn_of(200, 5), 1'b0, 1'b0, 1'b1, 20'h0C0DE, "R8 clean read");
    fill(vpn_of(200, 5), 20'h0C0DE, 1'b1);
    look(vpn_of(200, 5), 1'b1, 1'b0, 1'b1, 20'h0C0DE, "R8 dirty write");

    // R4: refill not visible in its own cycle
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn_of(300, 6); fill_pfn = 20'h11111; fill_dirty = 1'b1;
    lk_vpn = vpn_of(300, 6); lk_write = 1'b0; lk_req = 1'b0;
    #1 chk(lk_hit == 1'b0, "R4 same cycle", 32'(lk_hit), 32'd0);
    @(negedge clk); fill_en = 1'b0;
    #1 chk(lk_hit == 1'b1 && lk_pfn == 20'h11111, "R4 next cycle", 32'(lk_pfn), 32'h11111);

    // R9: flush together with refill discards the refill
    fill(vpn_of(400, 7), 20'h22222, 1'b1, 1'b1);
    look(vpn_of(400, 7), 1'b0, 1'b0, 1'b0, '0, "R9 flush+fill");
    look(vpn_of(104, 2), 1'b0, 1'b0, 1'b0, '0, "R9");
    look(vpn_of(300, 6), 1'b0, 1'b0, 1'b0, '0, "R9");

    summary();
  end
endmodule